// File: doc/BRIEF.md
# Exception Return Status Unwinder

This block updates the condition/status word of a processor core when a return from an exception or a return from a non-maskable interrupt retires. The status word holds a stack of saved flag groups. A return pops one level of that stack. It keeps the two top mode bits, clears the two bits just below them, and moves the lower 28 bits down by ten places.

After the pop, the block may set two flags. The previous-state flag is set unless the restore flag was set before the pop. The NMI-enable flag is set only by the NMI return. If the popped word shows user mode, the live stack pointer is parked as the kernel copy and the user stack pointer becomes live.

The pipeline presents one strobe together with the current status word, stack pointer and user stack pointer. All results are registered and commit on the same clock edge. With no strobe, the registered results hold their values.

Top module: `exret_unwind`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ccs_out`, `sp_out` and `ksp_out` are all zero until the first strobe.
- R2: On a return, result bits [31:30] equal input bits [31:30], bits [29:18] are zero, and bits [17:0] equal input bits [27:10]. Bits 7 and 10 may then be set by R3 and R4.
- R3: On either return, the previous-state flag (result bit 7) is forced to 1 when the restore flag (input bit 8) is 0. When input bit 8 is 1, result bit 7 is the shifted value, which is input bit 17.
- R4: An NMI return always sets result bit 10. An exception return leaves bit 10 at its shifted value, which is input bit 20.
- R5: If the user flag (bit 6) of the popped result is 1, `ksp_out` takes `sp_in` and `sp_out` takes `usp_in`.
- R6: If the user flag of the popped result is 0, `sp_out` takes `sp_in` and `ksp_out` keeps its value.
- R7: When both strobes are high, the block performs an NMI return.
- R8: With neither strobe high, `ccs_out`, `sp_out` and `ksp_out` keep their values, whatever the data inputs do.
- R9: Results appear on the outputs on the first rising clock edge at which the strobe is sampled high, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ret_exc | input | 1 | Exception return strobe |
| ret_nmi | input | 1 | NMI return strobe (has priority) |
| ccs_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | Saved user stack pointer |
| ccs_out | output | 32 | Registered status word after the return |
| sp_out | output | 32 | Registered live stack pointer |
| ksp_out | output | 32 | Registered kernel stack pointer copy |

## Verification
The following are checked on every cycle against the sampled inputs:
- the field layout after the pop;
- the conditional previous-state flag;
- the forced NMI-enable flag;
- both directions of the stack-pointer choice;
- the hold when no strobe is present.

The bench covers the things a property cannot show well:
- exact status words for edge patterns, such as all ones, only the gap bits set, and the restore flag with and without bit 17;
- the priority when both strobes are high;
- a kernel copy that persists across several returns;
- results that agree with the reference model over a run of pseudo-random words.

// File: rtl/exret_pkg.sv
package exret_pkg;
    // Status word layout
    localparam int CCS_W   = 32;
    localparam int KEEP_W  = 2;   // preserved top mode bits
    localparam int GAP_W   = 2;   // cleared bits below them
    localparam int POP_SH  = 10;  // width of one saved flag group

    // Flag positions after the pop
    localparam int C_BIT = 0;
    localparam int V_BIT = 1;
    localparam int Z_BIT = 2;
    localparam int N_BIT = 3;
    localparam int X_BIT = 4;
    localparam int I_BIT = 5;
    localparam int U_BIT = 6;
    localparam int P_BIT = 7;
    localparam int R_BIT = 8;
    localparam int M_BIT = 10;

    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_EXC  = 2'd1,
        RET_NMI  = 2'd2
    } ret_kind_e;
endpackage

// File: rtl/exret_kind_sel.sv
module exret_kind_sel
    import exret_pkg::*;
(
    input  logic      exc_stb,
    input  logic      nmi_stb,
    output ret_kind_e kind
);
    // The NMI return wins when both strobes are present
    always_comb begin
        if (nmi_stb)      kind = RET_NMI;
        else if (exc_stb) kind = RET_EXC;
        else              kind = RET_NONE;
    end
endmodule

// File: rtl/exret_ccs_pop.sv
module exret_ccs_pop
    import exret_pkg::*;
#(
    parameter int W      = 32,
    parameter int KEEP   = 2,
    parameter int GAP    = 2,
    parameter int SH     = 10,
    parameter int PBIT   = 7,
    parameter int RBIT   = 8,
    parameter int MBIT   = 10,
    parameter int UBIT   = 6
) (
    input  logic [W-1:0] ccs_old,
    input  ret_kind_e    kind,
    output logic [W-1:0] ccs_new,
    output logic         user_mode
);
    localparam int LOW_W = W - KEEP - GAP;
    localparam logic [W-1:0] LOW_MASK  = {{(KEEP+GAP){1'b0}}, {LOW_W{1'b1}}};
    localparam logic [W-1:0] KEEP_MASK = {{KEEP{1'b1}}, {(W-KEEP){1'b0}}};

    logic [W-1:0] popped;

    always_comb begin
        popped = (ccs_old & KEEP_MASK) | ((ccs_old & LOW_MASK) >> SH);
        // Previous-state flag depends on the restore flag before the pop
        if (!ccs_old[RBIT]) popped[PBIT] = 1'b1;
        ccs_new = popped;
        unique case (kind)
            RET_NMI:  ccs_new[MBIT] = 1'b1;
            RET_EXC:  ccs_new = popped;
            default:  ccs_new = popped;
        endcase
        user_mode = ccs_new[UBIT];
    end
endmodule

// File: rtl/exret_sp_swap.sv
module exret_sp_swap #(
    parameter int W = 32
) (
    input  logic         user_mode,
    input  logic [W-1:0] sp_cur,
    input  logic [W-1:0] usp_cur,
    input  logic [W-1:0] ksp_cur,
    output logic [W-1:0] sp_next,
    output logic [W-1:0] ksp_next
);
    always_comb begin
        if (user_mode) begin
            ksp_next = sp_cur;
            sp_next  = usp_cur;
        end else begin
            ksp_next = ksp_cur;
            sp_next  = sp_cur;
        end
    end
endmodule

// File: rtl/exret_unwind.sv
module exret_unwind
    import exret_pkg::*;
#(
    parameter int DATA_W = CCS_W,
    parameter int SP_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_exc,
    input  logic              ret_nmi,
    input  logic [DATA_W-1:0] ccs_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [SP_W-1:0]   usp_in,
    output logic [DATA_W-1:0] ccs_out,
    output logic [SP_W-1:0]   sp_out,
    output logic [SP_W-1:0]   ksp_out
);
    ret_kind_e         kind;
    logic [DATA_W-1:0] ccs_nx;
    logic              user_nx;
    logic [SP_W-1:0]   sp_nx, ksp_nx;
    logic [DATA_W-1:0] ccs_q;
    logic [SP_W-1:0]   sp_q, ksp_q;

    exret_kind_sel u_sel (
        .exc_stb (ret_exc),
        .nmi_stb (ret_nmi),
        .kind    (kind)
    );

    exret_ccs_pop #(
        .W(DATA_W), .KEEP(KEEP_W), .GAP(GAP_W), .SH(POP_SH),
        .PBIT(P_BIT), .RBIT(R_BIT), .MBIT(M_BIT), .UBIT(U_BIT)
    ) u_pop (
        .ccs_old   (ccs_in),
        .kind      (kind),
        .ccs_new   (ccs_nx),
        .user_mode (user_nx)
    );

    exret_sp_swap #(.W(SP_W)) u_swap (
        .user_mode (user_nx),
        .sp_cur    (sp_in),
        .usp_cur   (usp_in),
        .ksp_cur   (ksp_q),
        .sp_next   (sp_nx),
        .ksp_next  (ksp_nx)
    );

    // Single commit edge for all three results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccs_q <= '0;
            sp_q  <= '0;
            ksp_q <= '0;
        end else begin
            unique case (kind)
                RET_EXC, RET_NMI: begin
                    ccs_q <= ccs_nx;
                    sp_q  <= sp_nx;
                    ksp_q <= ksp_nx;
                end
                default: begin
                    ccs_q <= ccs_q;
                    sp_q  <= sp_q;
                    ksp_q <= ksp_q;
                end
            endcase
        end
    end

    assign ccs_out = ccs_q;
    assign sp_out  = sp_q;
    assign ksp_out = ksp_q;
endmodule

// File: rtl/exret_unwind_chk.sv
module exret_unwind_chk
    import exret_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SP_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ret_exc,
    input logic              ret_nmi,
    input logic [DATA_W-1:0] ccs_in,
    input logic [SP_W-1:0]   sp_in,
    input logic [SP_W-1:0]   usp_in,
    input logic [DATA_W-1:0] ccs_out,
    input logic [SP_W-1:0]   sp_out,
    input logic [SP_W-1:0]   ksp_out
);
    localparam int GAP_HI = DATA_W - KEEP_W - 1;
    localparam int GAP_LO = DATA_W - KEEP_W - GAP_W - POP_SH;
    logic commit;
    assign commit = ret_exc | ret_nmi;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (ccs_out == '0 && sp_out == '0 && ksp_out == '0));

    // R2
    field_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (ccs_out[DATA_W-1 -: KEEP_W] == $past(ccs_in[DATA_W-1 -: KEEP_W])
                    && ccs_out[GAP_HI:GAP_LO] == '0
                    && ccs_out[C_BIT +: 6] == $past(ccs_in[POP_SH +: 6])));

    // R3
    prev_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !ccs_in[R_BIT]) |=> ccs_out[P_BIT]);

    // R4
    nmi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_nmi |=> ccs_out[M_BIT]);

    // R5
    user_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ccs_in[U_BIT + POP_SH]) |=>
            (sp_out == $past(usp_in) && ksp_out == $past(sp_in)));

    // R6
    kernel_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !ccs_in[U_BIT + POP_SH]) |=>
            (sp_out == $past(sp_in) && $stable(ksp_out)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(ccs_out) && $stable(sp_out) && $stable(ksp_out)));
endmodule

bind exret_unwind exret_unwind_chk #(.DATA_W(DATA_W), .SP_W(SP_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ret_exc(ret_exc), .ret_nmi(ret_nmi),
    .ccs_in(ccs_in), .sp_in(sp_in), .usp_in(usp_in),
    .ccs_out(ccs_out), .sp_out(sp_out), .ksp_out(ksp_out)
);

// File: tb/exret_unwind_tb.sv
module exret_unwind_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_exc = 1'b0, ret_nmi = 1'b0;
    logic [31:0] ccs_in = '0, sp_in = '0, usp_in = '0;
    logic [31:0] ccs_out, sp_out, ksp_out;

    typedef struct {
        logic [31:0] ccs, sp, ksp;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_run = 0, n_fail = 0;
    logic [31:0] m_ccs = '0, m_sp = '0, m_ksp = '0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exret_unwind dut_i (
        .clk(clk), .rst_n(rst_n), .ret_exc(ret_exc), .ret_nmi(ret_nmi),
        .ccs_in(ccs_in), .sp_in(sp_in), .usp_in(usp_in),
        .ccs_out(ccs_out), .sp_out(sp_out), .ksp_out(ksp_out)
    );

    task automatic check(string req, logic [31:0] c, logic [31:0] s, logic [31:0] k,
                         logic [31:0] ec, logic [31:0] es, logic [31:0] ek);
        n_run++;
        if (c !== ec || s !== es || k !== ek) begin
            n_fail++;
            $display("FAIL %s ccs/sp/ksp actual %h/%h/%h expected %h/%h/%h",
                     req, c, s, k, ec, es, ek);
        end
    endtask

    // Driver: drive one cycle of stimulus and queue its expected result
    task automatic drive(bit e, bit n, logic [31:0] c, logic [31:0] s,
                         logic [31:0] u, string req);
        exp_t it;
        logic [31:0] nc;
        @(negedge clk);
        ret_exc = e; ret_nmi = n; ccs_in = c; sp_in = s; usp_in = u;
        if (e || n) begin
            // R2 layout, R3 prev-state flag, R4 NMI flag, R7 priority
            nc = {c[31:30], 12'b0, c[27:10]};
            if (!c[8]) nc[7] = 1'b1;
            if (n) nc[10] = 1'b1;
            m_ccs = nc;
            if (nc[6]) begin m_ksp = s; m_sp = u; end   // R5
            else       begin m_sp = s; end               // R6
        end
        it.ccs = m_ccs; it.sp = m_sp; it.ksp = m_ksp; it.req = req;
        q.push_back(it);
    endtask

    // Monitor: compare just after the commit edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                check(it.req, ccs_out, sp_out, ksp_out, it.ccs, it.sp, it.ksp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        lf = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R1 reset state, with inputs active during reset
        ret_exc = 1'b1; ccs_in = 32'hFFFF_FFFF; sp_in = 32'h55; usp_in = 32'h66;
        @(negedge clk);
        check("R1", ccs_out, sp_out, ksp_out, '0, '0, '0);
        ret_exc = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", ccs_out, sp_out, ksp_out, '0, '0, '0);

        // R9: stimulus applied, outputs unchanged before the edge
        drive(1, 0, 32'h0000_0000, 32'h1000, 32'h2000, "R2/R3 zero word");
        check("R9", ccs_out, sp_out, ksp_out, '0, '0, '0);
        drive(1, 0, 32'hFFFF_FFFF, 32'h1100, 32'h2200, "R2/R5 all ones");
        drive(1, 0, 32'h0000_0100, 32'h1200, 32'h2300, "R3 restore set");
        drive(1, 0, 32'h0002_0100, 32'h1300, 32'h2400, "R3 restore with bit17");
        drive(0, 1, 32'h0000_0000, 32'h1400, 32'h2500, "R4 NMI sets bit10");
        drive(1, 0, 32'h0010_0000, 32'h1500, 32'h2600, "R4 exc keeps bit20");
        drive(1, 0, 32'h3000_0000, 32'h1600, 32'h2700, "R2 gap cleared");
        drive(1, 0, 32'h8001_0000, 32'h1700, 32'h2800, "R5 user swap");
        drive(1, 0, 32'h4000_0000, 32'h1800, 32'h2900, "R6 kernel keeps ksp");
        drive(0, 0, 32'hDEAD_BEEF, 32'h9999, 32'h8888, "R8 hold");
        drive(0, 0, 32'h0001_0000, 32'h7777, 32'h6666, "R8 hold");
        drive(1, 1, 32'h0000_0100, 32'h1900, 32'h2A00, "R7 both strobes");
        drive(1, 1, 32'h0401_0000, 32'h1A00, 32'h2B00, "R7 both with user");
        for (int i = 0; i < 40; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            drive(lf[0], lf[1] & lf[2], lf, lf ^ 32'hA5A5_0000, ~lf, "R2..R8 sweep");
        end
        drive(0, 0, 32'h0, 32'h0, 32'h0, "R8 hold");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule